// File: doc/BRIEF.md
# Low-Side Pulse Stretcher with Current-Sense Window

This block sits in a synchronous buck controller between the PWM logic and the low-side gate driver. Current sensing reads the voltage across the low-side switch while it conducts. At high duty cycle the requested low-side pulse can be too short for a sense reading, or it can be missing altogether. The block counts switching periods whose low-side pulse never reaches a minimum width. On the period that would be the third such one in a row, it stretches the requested pulse to the minimum width. If no pulse is requested in that period, it inserts one just before the period ends. Sensing therefore happens at least once in every three periods.

The block also produces a sense-window strobe for the overcurrent comparator. The window opens only after the output gate has been high for a blanking interval, so that switching ringing has settled. It closes in the same cycle that the gate falls. A gate-enable input forces both outputs low and clears the history of narrow pulses. All timing parameters are counts of system clock cycles.

Top module: `ls_pulse_guard`

## Requirements
- R1: Outside a forced period, `ls_gate` reproduces `ls_req` delayed by exactly one clock cycle, with the same width.
- R2: `sense_win` is low during the first `BLANK_CYC` cycles of every `ls_gate` high run. It rises in the cycle numbered `BLANK_CYC`+1 of that run.
- R3: `sense_win` is high only while `ls_gate` is high. It stays high until the gate falls, so each run gives `width - BLANK_CYC` window cycles, or none if the width is `BLANK_CYC` or less.
- R4: A period is narrow when its `ls_gate` never stays high for `MIN_CYC` consecutive cycles. The period that follows `NARROW_LIMIT-1` consecutive narrow periods is forced. In a forced period, a requested pulse is held high for at least `MIN_CYC` cycles from its rising edge.
- R5: In a forced period with no request, a pulse of exactly `MIN_CYC` cycles is inserted. The gate rises `PERIOD_CYC - MIN_CYC` cycles after the cycle in which `period_strobe` was high, so the pulse ends before the next strobe.
- R6: A period whose gate reaches `MIN_CYC` consecutive high cycles clears the narrow-period count to zero.
- R7: The stretched or inserted pulse of a forced period counts as wide. The count therefore restarts, and forced periods recur at most every `NARROW_LIMIT` periods.
- R8: While `gate_en` is low, both outputs are low from the next cycle on, and the narrow-period count is cleared.
- R9: Time before the first `period_strobe` after reset or after `gate_en` rises is not counted as a period.
- R10: Under synchronous active-high reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_en | input | 1 | Low forces both outputs low and clears the count |
| period_strobe | input | 1 | One-cycle pulse that marks the start of a switching period |
| ls_req | input | 1 | Requested low-side gate from the PWM logic |
| ls_gate | output | 1 | Registered, possibly stretched or inserted low-side gate |
| sense_win | output | 1 | Registered current-sense window strobe |

## Verification
Some properties hold on every cycle, and the assertions check them. These are:
- the window is never open without the gate;
- the window is closed in the cycle the gate rises;
- a forced pulse never falls short of the minimum width;
- the count never exceeds its ceiling;
- disabling clears both outputs.

Other behaviour only shows across a sequence of whole periods, and only the bench scenarios can show it. This covers which period gets forced, where an inserted pulse lands, and how counting restarts after a wide pulse, after re-enable and after the first strobe. The bench sweeps every requested width from absent to well past the minimum, repeated over several periods, and also runs mixed and enable-toggling sequences.

// File: rtl/ls_guard_pkg.sv
package ls_guard_pkg;

  // Per-period status handed from the period tracker to the gate shaper.
  typedef struct packed {
    logic force_mode;   // current period must yield a sensable pulse
    logic wide_seen;    // a pulse of minimum width already occurred
    logic insert_slot;  // late enough in the period to insert a pulse
  } ls_track_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ls_period_tracker.sv
module ls_period_tracker
  import ls_guard_pkg::*;
#(
  parameter int unsigned PERIOD_CYC   = 333,
  parameter int unsigned MIN_CYC      = 85,
  parameter int unsigned NARROW_LIMIT = 3
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      en,
  input  logic      strobe,
  input  logic      wide_now,
  output ls_track_t track_o
);

  localparam int unsigned POS_MAX = PERIOD_CYC + 1;
  localparam int unsigned POS_W   = $clog2(POS_MAX + 1);
  localparam int unsigned INS_POS = PERIOD_CYC - MIN_CYC - 1;
  localparam int unsigned CNT_W   = (NARROW_LIMIT > 2) ? $clog2(NARROW_LIMIT) : 1;

  localparam logic [POS_W-1:0] POS_TOP  = POS_W'(POS_MAX);
  localparam logic [POS_W-1:0] POS_INS  = POS_W'(INS_POS);
  localparam logic [POS_W-1:0] POS_END  = POS_W'(PERIOD_CYC);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(NARROW_LIMIT - 1);

  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_next;
  logic             armed_q;
  logic             force_q;
  logic             wide_seen_q;
  logic             period_wide;

  always_comb begin
    period_wide = wide_seen_q | wide_now;
    if (period_wide)          cnt_next = '0;
    else if (cnt_q == CNT_TOP) cnt_next = CNT_TOP;
    else                       cnt_next = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pos_q       <= '0;
      cnt_q       <= '0;
      armed_q     <= 1'b0;
      force_q     <= 1'b0;
      wide_seen_q <= 1'b0;
    end else if (strobe) begin
      pos_q       <= POS_W'(1);
      wide_seen_q <= 1'b0;
      armed_q     <= 1'b1;
      if (armed_q) begin
        cnt_q   <= cnt_next;
        force_q <= (cnt_next == CNT_TOP);
      end else begin
        cnt_q   <= '0;
        force_q <= 1'b0;
      end
    end else begin
      if (pos_q != POS_TOP) pos_q <= pos_q + 1'b1;
      wide_seen_q <= period_wide;
    end
  end

  always_comb begin
    track_o.force_mode  = force_q;
    track_o.wide_seen   = wide_seen_q;
    track_o.insert_slot = (pos_q >= POS_INS) && (pos_q < POS_END);
  end

  // R4: the narrow count never climbs past its ceiling.
  p_cnt_cap_r4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_TOP);

  // R4: a period only becomes forced at a period boundary.
  p_force_at_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(force_q) |-> $past(strobe));

  // R9: nothing is forced before the first boundary has been seen.
  p_unarmed_r9: assert property (@(posedge clk) disable iff (rst)
    !armed_q |-> !force_q);

endmodule

// File: rtl/ls_gate_shaper.sv
module ls_gate_shaper
  import ls_guard_pkg::*;
#(
  parameter int unsigned MIN_CYC = 85,
  parameter int unsigned RUN_MAX = 85,
  parameter int unsigned RUN_W   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ls_req,
  input  ls_track_t        track_i,
  output logic             gate_o,
  output logic             gate_next_o,
  output logic [RUN_W-1:0] run_next_o,
  output logic             wide_now_o
);

  localparam logic [RUN_W-1:0] MIN_R = RUN_W'(MIN_CYC);
  localparam logic [RUN_W-1:0] TOP_R = RUN_W'(RUN_MAX);

  logic             gate_q;
  logic [RUN_W-1:0] run_q;
  logic             hold;
  logic             insert;
  logic             gate_d;
  logic [RUN_W-1:0] run_d;

  always_comb begin
    hold   = track_i.force_mode & gate_q & (run_q < MIN_R);
    insert = track_i.force_mode & ~track_i.wide_seen & ~gate_q & track_i.insert_slot;
    gate_d = en & (ls_req | hold | insert);
    if (!gate_d)           run_d = '0;
    else if (!gate_q)      run_d = RUN_W'(1);
    else if (run_q == TOP_R) run_d = TOP_R;
    else                   run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= 1'b0;
      run_q  <= '0;
    end else begin
      gate_q <= gate_d;
      run_q  <= run_d;
    end
  end

  assign gate_o      = gate_q;
  assign gate_next_o = gate_d;
  assign run_next_o  = run_d;
  assign wide_now_o  = gate_q & (run_q >= MIN_R);

  // R4: in a forced period the gate never falls before the minimum width.
  p_min_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && $past(track_i.force_mode) && $fell(gate_q))
      |-> ($past(run_q) >= MIN_R));

endmodule

// File: rtl/ls_sense_window.sv
module ls_sense_window #(
  parameter int unsigned BLANK_CYC = 40,
  parameter int unsigned RUN_W     = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             gate_next_i,
  input  logic [RUN_W-1:0] run_next_i,
  output logic             sense_o
);

  localparam logic [RUN_W-1:0] BLANK_R = RUN_W'(BLANK_CYC);

  logic sense_q;

  always_ff @(posedge clk) begin
    if (rst) sense_q <= 1'b0;
    else     sense_q <= en & gate_next_i & (run_next_i > BLANK_R);
  end

  assign sense_o = sense_q;

endmodule

// File: rtl/ls_pulse_guard.sv
module ls_pulse_guard
  import ls_guard_pkg::*;
#(
  parameter int unsigned PERIOD_CYC   = 333,
  parameter int unsigned MIN_CYC      = 85,
  parameter int unsigned BLANK_CYC    = 40,
  parameter int unsigned NARROW_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_en,
  input  logic period_strobe,
  input  logic ls_req,
  output logic ls_gate,
  output logic sense_win
);

  localparam int unsigned RUN_MAX = max_u(MIN_CYC, BLANK_CYC + 1);
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

  ls_track_t        track;
  logic             wide_now;
  logic             gate_next;
  logic [RUN_W-1:0] run_next;

  ls_period_tracker #(
    .PERIOD_CYC  (PERIOD_CYC),
    .MIN_CYC     (MIN_CYC),
    .NARROW_LIMIT(NARROW_LIMIT)
  ) tracker_i (
    .clk     (clk),
    .rst     (rst),
    .en      (gate_en),
    .strobe  (period_strobe),
    .wide_now(wide_now),
    .track_o (track)
  );

  ls_gate_shaper #(
    .MIN_CYC(MIN_CYC),
    .RUN_MAX(RUN_MAX),
    .RUN_W  (RUN_W)
  ) shaper_i (
    .clk        (clk),
    .rst        (rst),
    .en         (gate_en),
    .ls_req     (ls_req),
    .track_i    (track),
    .gate_o     (ls_gate),
    .gate_next_o(gate_next),
    .run_next_o (run_next),
    .wide_now_o (wide_now)
  );

  ls_sense_window #(
    .BLANK_CYC(BLANK_CYC),
    .RUN_W    (RUN_W)
  ) window_i (
    .clk        (clk),
    .rst        (rst),
    .en         (gate_en),
    .gate_next_i(gate_next),
    .run_next_i (run_next),
    .sense_o    (sense_win)
  );

  // R3: the sense window is open only while the gate is high.
  p_sense_in_gate_r3: assert property (@(posedge clk) disable iff (rst)
    sense_win |-> ls_gate);

  // R2: the window is closed in the cycle the gate rises.
  p_rise_blanked_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_gate) |-> !sense_win);

  // R2: the window opens only after at least one earlier gate-high cycle.
  p_open_after_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sense_win) |-> $past(ls_gate));

  // R8: a low enable clears both outputs on the next cycle.
  p_disable_r8: assert property (@(posedge clk) disable iff (rst)
    !gate_en |=> (!ls_gate && !sense_win));

endmodule

// File: tb/ls_pulse_guard_tb.sv
`timescale 1ns/1ps
module ls_pulse_guard_tb_top;

  localparam int P     = 40;
  localparam int MINW  = 8;
  localparam int BLANK = 3;
  localparam int LIM   = 3;
  localparam int S     = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_en = 1'b0;
  logic period_strobe = 1'b0;
  logic ls_req = 1'b0;
  logic ls_gate;
  logic sense_win;

  int checks = 0;
  int fails = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ls_pulse_guard #(
    .PERIOD_CYC  (P),
    .MIN_CYC     (MINW),
    .BLANK_CYC   (BLANK),
    .NARROW_LIMIT(LIM)
  ) dut_i (
    .clk          (clk),
    .rst          (rst),
    .gate_en      (gate_en),
    .period_strobe(period_strobe),
    .ls_req       (ls_req),
    .ls_gate      (ls_gate),
    .sense_win    (sense_win)
  );

  task automatic check(input string tag, input string ctx, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  // One switching period: request of width w starting at offset S.
  task automatic run_period(input int w, input bit en_v, input string ctx);
    int g_cnt = 0;
    int s_cnt = 0;
    int g_first = -1;
    int s_first = -1;
    bit forced;
    int exp_w, exp_first, exp_s, exp_sfirst;
    for (int k = 0; k < P; k++) begin
      @(posedge clk); #1;
      gate_en       = en_v;
      period_strobe = (k == 0);
      ls_req        = (k >= S) && (k < S + w);
      @(negedge clk);
      if (ls_gate) begin
        g_cnt++;
        if (g_first < 0) g_first = k;
      end
      if (sense_win) begin
        s_cnt++;
        if (s_first < 0) s_first = k;
      end
    end
    if (!en_v) begin
      exp_w = 0; exp_first = -1; exp_cnt = 0;
      check("R8", ctx, g_cnt, 0);
      check("R8", ctx, s_cnt, 0);
    end else begin
      forced = (exp_cnt == LIM - 1);
      if (w > 0) begin
        exp_w     = (forced && w < MINW) ? MINW : w;
        exp_first = S + 1;
      end else begin
        exp_w     = forced ? MINW : 0;
        exp_first = forced ? P - MINW : -1;
      end
      exp_s      = (exp_w > BLANK) ? exp_w - BLANK : 0;
      exp_sfirst = (exp_w > BLANK) ? exp_first + BLANK : -1;
      if (forced && w == 0) begin
        check("R5", ctx, g_cnt, exp_w);
        check("R5", ctx, g_first, exp_first);
      end else if (forced) begin
        check("R4", ctx, g_cnt, exp_w);
        check("R4", ctx, g_first, exp_first);
      end else begin
        check("R1", ctx, g_cnt, exp_w);
        check("R1", ctx, g_first, exp_first);
      end
      check("R3", ctx, s_cnt, exp_s);
      check("R2", ctx, s_first, exp_sfirst);
      // R6 / R7: wide periods (including forced ones) restart the count
      if (exp_w >= MINW) exp_cnt = 0;
      else if (exp_cnt < LIM - 1) exp_cnt++;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: outputs low under reset even with request and enable high
    gate_en = 1'b1;
    ls_req  = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10", "reset", int'(ls_gate), 0);
    check("R10", "reset", int'(sense_win), 0);
    @(posedge clk); #1;
    rst    = 1'b0;
    ls_req = 1'b0;

    // R9: narrow pulses before the first strobe must not be counted
    for (int c = 0; c < 30; c++) begin
      @(posedge clk); #1;
      ls_req = ((c % 10) < 2);
    end
    exp_cnt = 0;
    run_period(2, 1'b1, "R9 first period");
    run_period(2, 1'b1, "R9 second period");
    run_period(2, 1'b1, "R9 third period forced");

    // Sweep every requested width over several periods
    for (int w = 0; w <= 20; w++) begin
      for (int r = 0; r < 4; r++) run_period(w, 1'b1, $sformatf("sweep w=%0d rep=%0d", w, r));
    end

    // R6: a wide pulse between narrow ones restarts counting
    run_period(20, 1'b1, "R6 wide");
    run_period(2, 1'b1, "R6 narrow a");
    run_period(20, 1'b1, "R6 wide again");
    run_period(2, 1'b1, "R6 narrow b");
    run_period(2, 1'b1, "R6 narrow c");
    run_period(2, 1'b1, "R7 forced");
    run_period(2, 1'b1, "R7 restart a");
    run_period(0, 1'b1, "R7 restart b");
    run_period(0, 1'b1, "R7 inserted");

    // R8: disable clears outputs and the count
    run_period(2, 1'b1, "R8 narrow a");
    run_period(2, 1'b1, "R8 narrow b");
    run_period(15, 1'b0, "R8 disabled");
    run_period(2, 1'b1, "R8 after enable a");
    run_period(2, 1'b1, "R8 after enable b");
    run_period(2, 1'b1, "R8 after enable forced");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule